// File: doc/BRIEF.md
# Configuration Register Target on a Two-Wire Serial Bus

This block is a serial-bus target that holds six bytes of configuration for a clock generator. A host writes the bytes with block writes and reads them back with block reads, in standard mode (100 kbit/s or slower). A much faster system clock samples both bus lines. Each line passes through a two-flop synchronizer and a glitch filter before START, STOP and clock-edge detection. The block drives the data line only by pulling it low, through `sda_pull_o`.

A write opens with address byte 0xD2. The host then sends two bytes that are acknowledged and thrown away: a command code, then a byte count. After those come the data bytes. They always land from byte 0 upward and may stop after any complete byte. A read opens with 0xD3. The target answers with a count byte of 6 and then bytes 0 to 5.

At reset the register file loads fixed defaults. The low bits of byte 5 take the inverse of the strap pins, as sampled in the last reset cycle.

Top module: `cfg_i2c_target`

## Requirements
- R1: Only the address bytes 0xD2 (write) and 0xD3 (read) are acknowledged. Any other address is NACKed, and the target ignores the bus until the next START.
- R2: On a write, the two bytes after the address (command code, then byte count) are each ACKed, and their values have no effect on the registers or on how many data bytes are accepted.
- R3: Write data bytes are stored in order: the first data byte goes to byte 0, the next to byte 1, and so on up to byte 5. Each stored byte is ACKed.
- R4: A STOP after any complete data byte ends the write. Bytes already written keep their new values, and the higher bytes keep their previous values.
- R5: Data bytes beyond the sixth in one write are NACKed and dropped. The registers keep the first six bytes.
- R6: On a read, the target sends the count byte 0x06 and then bytes 0 to 5 in order, MSB first, as long as the host ACKs each byte.
- R7: When the host NACKs a read byte, the target releases SDA (later clocked bits read 0xFF) and waits for STOP or a repeated START. A later read then works normally.
- R8: After reset, byte 0 = 0x00, bytes 1 to 4 = 0xFF, and byte 5 bits [7:5] = 3'b111.
- R9: Byte 5 bits [4:0] hold the inverse of `strap_i[4:0]` as sampled in the last reset cycle. Changes on `strap_i` after reset have no effect.
- R10: The target changes `sda_pull_o` only while SCL is low, and it pulls SDA low during the ninth clock pulse to ACK.
- R11: A pulse on SCL shorter than `FILT_CYC` system clocks is not seen as a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset; straps are sampled while it is low |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | STRAP_W | Strap pin levels, sampled during reset |
| sda_pull_o | output | 1 | 1 pulls SDA low (open drain) |
| cfg_o | output | NUM_BYTES*8 | Register file; byte n sits at bits [8n+7:8n] |

## Verification
A table of block writes is applied, each followed by a full bus read-back. The table has a full six-byte write, a three-byte partial write, a write with no data, and an eight-byte overrun. Between them, these separate the in-order fill from a count-driven fill, show that the written count byte is discarded, and show that bytes 7 and 8 are rejected.

Directed cases cover the following:
- the reset defaults and the strap inversion, including strap changes after reset;
- an unknown address followed by a clocked data byte;
- a host NACK in mid-read, with the released line checked over the next byte;
- an address byte with short SCL spikes in every bit, which only a working filter accepts.

// File: rtl/cfg_i2c_pkg.sv
// Shared constants and types for the serial configuration target.
package cfg_i2c_pkg;
    localparam int unsigned NUM_BYTES = 6;
    localparam int unsigned BYTE_W    = 8;
    localparam logic [7:0]  WR_ADDR   = 8'hD2;
    localparam logic [7:0]  RD_ADDR   = 8'hD3;

    // Transfer phase of the target engine
    typedef enum logic [2:0] {
        ST_IDLE,   // not addressed
        ST_RX,     // shifting in a byte from the host
        ST_ACK,    // ninth pulse of a received byte
        ST_TX,     // shifting out a byte to the host
        ST_HACK,   // ninth pulse of a sent byte, host answers
        ST_WAIT    // read ended by NACK, wait for STOP or START
    } xfer_st_t;

    // Which byte of a write frame is being received
    typedef enum logic [1:0] {
        RX_ADDR,
        RX_CMD,
        RX_CNT,
        RX_DATA
    } rx_stage_t;
endpackage

// File: rtl/cfg_i2c_deglitch.sv
// Two-flop synchronizer plus a glitch filter for one bus line.
// Assumes: the line idles high; the output follows the input only after
// the synchronized value has differed for FILT_CYC consecutive cycles.
module cfg_i2c_deglitch #(
    parameter int unsigned FILT_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);
    localparam int unsigned CNT_W = $clog2(FILT_CYC + 1);

    logic             sync1, sync2;
    logic [CNT_W-1:0] run_cnt;

    // Bring the pad level into the clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
        end else begin
            sync1 <= raw_i;
            sync2 <= sync1;
        end
    end

    // Accept a new level only once it has persisted long enough
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clean_o <= 1'b1;
            run_cnt <= '0;
        end else if (sync2 == clean_o) begin
            run_cnt <= '0;
        end else if (run_cnt == CNT_W'(FILT_CYC - 1)) begin
            clean_o <= sync2;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/cfg_i2c_bus_cond.sv
// Detects START, STOP and SCL edges from filtered bus lines.
// Assumes: inputs are already synchronous and glitch-free.
module cfg_i2c_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic start_o,
    output logic stop_o,
    output logic scl_rise_o,
    output logic scl_fall_o
);
    logic scl_q, sda_q;

    // Remember the previous line levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    // SDA moving while SCL stays high marks a frame boundary
    always_comb begin
        start_o    = scl_q && scl_f && sda_q && !sda_f;
        stop_o     = scl_q && scl_f && !sda_q && sda_f;
        scl_rise_o = !scl_q && scl_f;
        scl_fall_o = scl_q && !scl_f;
    end
endmodule

// File: rtl/cfg_i2c_regfile.sv
// Configuration register file with strap-seeded reset values.
// Assumes: one write port from the protocol engine; strap bits occupy the
// low STRAP_W bits of the last byte and load inverted during every reset cycle.
module cfg_i2c_regfile #(
    parameter int unsigned NUM_BYTES = 6,
    parameter int unsigned BYTE_W    = 8,
    parameter int unsigned STRAP_W   = 5,
    parameter int unsigned PTR_W     = 3,
    parameter logic [NUM_BYTES*BYTE_W-1:0] CFG_DEFAULT = '0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [STRAP_W-1:0]          strap_i,
    input  logic                        we_i,
    input  logic [PTR_W-1:0]            wr_idx_i,
    input  logic [BYTE_W-1:0]           wdata_i,
    input  logic [PTR_W-1:0]            rd_idx_i,
    output logic [BYTE_W-1:0]           rd_data_o,
    output logic [NUM_BYTES*BYTE_W-1:0] cfg_o
);
    localparam logic [BYTE_W-1:0] STRAP_MASK = BYTE_W'((1 << STRAP_W) - 1);

    logic [BYTE_W-1:0] regs [NUM_BYTES];

    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
        logic [BYTE_W-1:0] rst_val;
        if (b == NUM_BYTES - 1) begin : g_strap
            // Last byte carries the inverted strap levels in its low bits
            assign rst_val = (CFG_DEFAULT[b*BYTE_W +: BYTE_W] & ~STRAP_MASK)
                           | (~BYTE_W'(strap_i) & STRAP_MASK);
        end else begin : g_plain
            assign rst_val = CFG_DEFAULT[b*BYTE_W +: BYTE_W];
        end

        // Hold one configuration byte
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[b] <= rst_val;
            end else if (we_i && wr_idx_i == PTR_W'(b)) begin
                regs[b] <= wdata_i;
            end
        end

        assign cfg_o[b*BYTE_W +: BYTE_W] = regs[b];
    end

    // Read port for the transmit path
    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < NUM_BYTES; i++) begin
            if (rd_idx_i == PTR_W'(i)) rd_data_o = regs[i];
        end
    end
endmodule

// File: rtl/cfg_i2c_target.sv
// Serial-bus configuration target: block writes (address, discarded command
// and count, then data from byte 0 up) and block reads (count, then bytes).
// Assumes: clk is many times faster than SCL; no clock stretching.
module cfg_i2c_target
    import cfg_i2c_pkg::*;
#(
    parameter int unsigned FILT_CYC = 3,
    parameter int unsigned STRAP_W  = 5,
    parameter logic [NUM_BYTES*BYTE_W-1:0] CFG_DEFAULT = 48'hE0FF_FFFF_FF00
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        scl_i,
    input  logic                        sda_i,
    input  logic [STRAP_W-1:0]          strap_i,
    output logic                        sda_pull_o,
    output logic [NUM_BYTES*BYTE_W-1:0] cfg_o
);
    localparam int unsigned PTR_W = $clog2(NUM_BYTES + 1);
    localparam logic [BYTE_W-1:0] COUNT_BYTE = BYTE_W'(NUM_BYTES);

    logic scl_f, sda_f;
    logic start_det, stop_det, scl_rise, scl_fall;

    xfer_st_t          state;
    rx_stage_t         rx_stage;
    logic              is_read;
    logic [3:0]        bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_idx;
    logic [PTR_W-1:0]  rd_sel;
    logic              host_ack;
    logic              reg_we;
    logic [BYTE_W-1:0] rd_data;
    logic              byte_done;

    cfg_i2c_deglitch #(.FILT_CYC(FILT_CYC)) i_scl_filt (
        .clk(clk), .rst_n(rst_n), .raw_i(scl_i), .clean_o(scl_f)
    );
    cfg_i2c_deglitch #(.FILT_CYC(FILT_CYC)) i_sda_filt (
        .clk(clk), .rst_n(rst_n), .raw_i(sda_i), .clean_o(sda_f)
    );

    cfg_i2c_bus_cond i_cond (
        .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
        .start_o(start_det), .stop_o(stop_det),
        .scl_rise_o(scl_rise), .scl_fall_o(scl_fall)
    );

    cfg_i2c_regfile #(
        .NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W), .STRAP_W(STRAP_W),
        .PTR_W(PTR_W), .CFG_DEFAULT(CFG_DEFAULT)
    ) i_regs (
        .clk(clk), .rst_n(rst_n), .strap_i(strap_i),
        .we_i(reg_we), .wr_idx_i(wr_ptr), .wdata_i(shreg),
        .rd_idx_i(rd_sel), .rd_data_o(rd_data), .cfg_o(cfg_o)
    );

    // Received byte is complete at the falling edge after its eighth bit
    assign byte_done = (state == ST_RX) && scl_fall && (bit_cnt == 4'd8)
                     && !start_det && !stop_det;
    // Store a data byte while the register file still has room
    assign reg_we = byte_done && (rx_stage == RX_DATA)
                  && (wr_ptr < PTR_W'(NUM_BYTES));
    // Read index 1..NUM_BYTES maps to register 0..NUM_BYTES-1
    assign rd_sel = rd_idx - 1'b1;

    // Protocol engine: framing, addressing, acknowledge and shifting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            rx_stage   <= RX_ADDR;
            is_read    <= 1'b0;
            bit_cnt    <= '0;
            shreg      <= '0;
            wr_ptr     <= '0;
            rd_idx     <= '0;
            host_ack   <= 1'b0;
            sda_pull_o <= 1'b0;
        end else if (start_det) begin
            state      <= ST_RX;
            rx_stage   <= RX_ADDR;
            bit_cnt    <= '0;
            wr_ptr     <= '0;
            rd_idx     <= '0;
            sda_pull_o <= 1'b0;
        end else if (stop_det) begin
            state      <= ST_IDLE;
            sda_pull_o <= 1'b0;
        end else begin
            case (state)
                ST_RX: begin
                    if (scl_rise) begin
                        shreg   <= {shreg[BYTE_W-2:0], sda_f};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (byte_done) begin
                        bit_cnt <= '0;
                        state   <= ST_ACK;
                        case (rx_stage)
                            RX_ADDR: begin
                                if (shreg == WR_ADDR || shreg == RD_ADDR) begin
                                    is_read    <= (shreg == RD_ADDR);
                                    sda_pull_o <= 1'b1;
                                    rx_stage   <= RX_CMD;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end
                            RX_CMD: begin
                                sda_pull_o <= 1'b1;
                                rx_stage   <= RX_CNT;
                            end
                            RX_CNT: begin
                                sda_pull_o <= 1'b1;
                                rx_stage   <= RX_DATA;
                            end
                            default: begin
                                if (wr_ptr < PTR_W'(NUM_BYTES)) begin
                                    sda_pull_o <= 1'b1;
                                    wr_ptr     <= wr_ptr + 1'b1;
                                end
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        if (is_read) begin
                            state      <= ST_TX;
                            shreg      <= COUNT_BYTE;
                            sda_pull_o <= !COUNT_BYTE[BYTE_W-1];
                            rd_idx     <= PTR_W'(1);
                        end else begin
                            state      <= ST_RX;
                            sda_pull_o <= 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (bit_cnt == 4'd8) begin
                            bit_cnt    <= '0;
                            sda_pull_o <= 1'b0;
                            state      <= ST_HACK;
                        end else begin
                            shreg      <= {shreg[BYTE_W-2:0], 1'b0};
                            sda_pull_o <= !shreg[BYTE_W-2];
                        end
                    end
                end
                ST_HACK: begin
                    if (scl_rise) begin
                        host_ack <= !sda_f;
                    end else if (scl_fall) begin
                        if (host_ack && rd_idx <= PTR_W'(NUM_BYTES)) begin
                            state      <= ST_TX;
                            shreg      <= rd_data;
                            sda_pull_o <= !rd_data[BYTE_W-1];
                            rd_idx     <= rd_idx + 1'b1;
                        end else begin
                            state <= ST_WAIT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cfg_i2c_target_chk.sv
// Property checker for cfg_i2c_target, attached by bind below.
// Assumes: it observes the filtered SCL and engine state of the target.
module cfg_i2c_target_chk
    import cfg_i2c_pkg::*;
#(
    parameter int unsigned PTR_W = 3,
    parameter int unsigned CFG_W = 48
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_f,
    input logic             sda_pull_o,
    input xfer_st_t         state,
    input logic [PTR_W-1:0] wr_ptr,
    input logic             reg_we,
    input logic [CFG_W-1:0] cfg_o
);
    // R1: an unaddressed target never pulls the line
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_pull_o);

    // R10: the pull changes only while SCL is low
    p_pull_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_o) |-> !scl_f);

    // R5: the write pointer never passes the register count
    p_ptr_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ptr <= PTR_W'(NUM_BYTES));

    // R4: without a write strobe the register file holds its contents
    p_cfg_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we |=> $stable(cfg_o));

    // R8: byte 0 comes out of reset as zero
    p_reset_byte0_r8: assert property (@(posedge clk)
        !rst_n |=> (cfg_o[7:0] == 8'h00));

    // R7: after a host NACK the line is released
    p_wait_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> !sda_pull_o);
endmodule

bind cfg_i2c_target cfg_i2c_target_chk #(
    .PTR_W(PTR_W), .CFG_W(NUM_BYTES*BYTE_W)
) i_chk (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_pull_o(sda_pull_o),
    .state(state), .wr_ptr(wr_ptr), .reg_we(reg_we), .cfg_o(cfg_o)
);

// File: tb/test_cfg_i2c_target.sv
// Bench for cfg_i2c_target: table-driven block writes with bus read-back,
// then directed reset, strap, address, NACK and glitch cases.
module test_cfg_i2c_target;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 12;   // system clocks per quarter bit
    localparam int NVEC       = 4;
    // {data byte count, bytes 5..0}; byte 0 in bits [7:0]
    localparam logic [51:0] VEC [NVEC] = '{
        {4'd6, 48'h6655_4433_2211},
        {4'd3, 48'h0000_00C3_B2A1},
        {4'd0, 48'h0000_0000_0000},
        {4'd8, 48'h1F2E_3D4C_5B6A}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        host_sda = 1'b1;
    logic [4:0]  strap = 5'b10110;
    logic        sda_pull;
    logic [47:0] cfg;
    wire         sda_bus = host_sda & ~sda_pull;

    int checks = 0;
    int fails  = 0;
    int r10_viol = 0;
    bit done = 1'b0;
    logic [47:0] exp_cfg;

    cfg_i2c_target i_cfg_i2c_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .strap_i(strap), .sda_pull_o(sda_pull), .cfg_o(cfg)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // R10: count pull changes while the host holds SCL high
    logic pull_q = 1'b0;
    always @(negedge clk) begin
        if (rst_n && scl && pull_q != sda_pull) r10_viol++;
        pull_q <= sda_pull;
    end

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        wclk(Q); host_sda = 1'b1;
        wclk(Q); scl = 1'b1;
        wclk(Q); host_sda = 1'b0;
        wclk(Q); scl = 1'b0;
    endtask

    task automatic bus_stop();
        wclk(Q); host_sda = 1'b0;
        wclk(Q); scl = 1'b1;
        wclk(Q); host_sda = 1'b1;
        wclk(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            if (glitch) begin
                wclk(4); scl = 1'b1; wclk(2); scl = 1'b0; wclk(Q - 6);
            end else begin
                wclk(Q);
            end
            host_sda = b[i];
            wclk(Q); scl = 1'b1;
            wclk(2*Q); scl = 1'b0;
        end
        wclk(Q); host_sda = 1'b1;
        wclk(Q); scl = 1'b1;
        wclk(Q); acked = !sda_bus;
        wclk(Q); scl = 1'b0;
    endtask

    task automatic recv_byte(input bit ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            wclk(Q); host_sda = 1'b1;
            wclk(Q); scl = 1'b1;
            wclk(Q); b[i] = sda_bus;
            wclk(Q); scl = 1'b0;
        end
        wclk(Q); host_sda = ack ? 1'b0 : 1'b1;
        wclk(Q); scl = 1'b1;
        wclk(2*Q); scl = 1'b0;
        wclk(Q); host_sda = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        bit          ack;
        logic [7:0]  rb;
        wclk(5);
        rst_n = 1'b1;
        wclk(2);
        // R8 R9: defaults and inverted strap 10110 -> byte 5 = 0xE9
        exp_cfg = 48'hE9FF_FFFF_FF00;
        chk(cfg == exp_cfg, "R8 R9 reset contents", cfg, exp_cfg);
        strap = 5'b00001;
        wclk(10);
        chk(cfg[47:40] == 8'hE9, "R9 strap change after reset ignored", cfg[47:40], 8'hE9);

        // Table: block write, then compare ports and a bus read-back
        for (int v = 0; v < NVEC; v++) begin
            int n;
            n = int'(VEC[v][51:48]);
            bus_start();
            send_byte(8'hD2, 1'b0, ack);
            chk(ack, "R1 write address acked", ack, 1);
            send_byte(8'h03, 1'b0, ack);   // R2 command code, value discarded
            chk(ack, "R2 command code acked", ack, 1);
            send_byte(8'h02, 1'b0, ack);   // R2 count byte, value discarded
            chk(ack, "R2 count byte acked", ack, 1);
            for (int k = 0; k < n; k++) begin
                logic [7:0] d;
                d = (k < 6) ? VEC[v][k*8 +: 8] : 8'h99;
                send_byte(d, 1'b0, ack);
                if (k < 6) begin
                    exp_cfg[k*8 +: 8] = d;
                    chk(ack, "R3 data byte acked", ack, 1);
                end else begin
                    chk(!ack, "R5 extra byte nacked", ack, 0);
                end
            end
            bus_stop();
            wclk(4);
            chk(cfg == exp_cfg, "R3 R4 R5 registers after write", cfg, exp_cfg);
            bus_start();
            send_byte(8'hD3, 1'b0, ack);
            chk(ack, "R1 read address acked", ack, 1);
            recv_byte(1'b1, rb);
            chk(rb == 8'h06, "R6 count byte", rb, 8'h06);
            for (int k = 0; k < 6; k++) begin
                recv_byte(1'b1, rb);
                chk(rb == exp_cfg[k*8 +: 8], "R6 read byte", rb, exp_cfg[k*8 +: 8]);
            end
            bus_stop();
        end

        // R1: foreign address is nacked and the following byte is ignored
        bus_start();
        send_byte(8'hA4, 1'b0, ack);
        chk(!ack, "R1 foreign address nacked", ack, 0);
        send_byte(8'h00, 1'b0, ack);
        chk(!ack, "R1 byte after foreign address nacked", ack, 0);
        bus_stop();
        wclk(4);
        chk(cfg == exp_cfg, "R1 registers untouched", cfg, exp_cfg);

        // R7: host NACK releases the line, then a new read still works
        bus_start();
        send_byte(8'hD3, 1'b0, ack);
        recv_byte(1'b1, rb);
        recv_byte(1'b0, rb);
        chk(rb == exp_cfg[7:0], "R7 byte before nack", rb, exp_cfg[7:0]);
        recv_byte(1'b0, rb);
        chk(rb == 8'hFF, "R7 line released after nack", rb, 8'hFF);
        bus_start();
        send_byte(8'hD3, 1'b0, ack);
        chk(ack, "R7 repeated start read acked", ack, 1);
        recv_byte(1'b1, rb);
        chk(rb == 8'h06, "R7 count after recovery", rb, 8'h06);
        recv_byte(1'b0, rb);
        bus_stop();

        // R11: SCL spikes of two clocks inside every bit are filtered out
        bus_start();
        send_byte(8'hD2, 1'b1, ack);
        chk(ack, "R11 address with scl spikes acked", ack, 1);
        bus_stop();
        wclk(4);
        chk(cfg == exp_cfg, "R11 registers unchanged", cfg, exp_cfg);

        chk(r10_viol == 0, "R10 pull changed with scl high", r10_viol, 0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule